// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core from its running program into a handler when a synchronous event (a fault or a trap) or an external interrupt comes in. On accepting a request it captures the architectural state that the return frame needs. It checks the requested vector against the descriptor-table limit and fetches one 64-bit gate descriptor through a read port. It then pushes the return frame through a word-wide write port, one word per cycle. When the frame is written, it presents the handler's code selector and entry offset, the final stack selector and pointer, and the working flags, and it pulses `done`.

The frame depends on where the event was raised. If the core was in user mode, the block switches to the kernel stack taken from the task-state values, saves the old stack selector and pointer, and then saves flags, code selector and return offset. If the core was already in kernel mode, it stays on the current stack and saves only the last three. The return offset depends on the event kind. A fault saves the address of the faulting instruction so that it runs again. A trap or an interrupt saves the address of the next instruction. When the step flag is set, the block also produces a debug trap on vector 1 after each retired instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: Among requests present in the same idle cycle, the order is fault first, then an explicit trap, then the single-step trap, then an external interrupt. An interrupt is taken only while flag bit 9 (interrupt enable) of `cur_eflags` is 1; otherwise it is dropped and `busy` stays low.
- R2: The saved return offset is `cur_eip` for a fault and `next_eip` for a trap, a single-step trap or an interrupt.
- R3: With `user_mode` = 1, the stack pointer starts from `tss_esp` and `new_ss` is `tss_ss`. Five words are pushed in this order: old `cur_ss` (zero-extended), old `cur_esp`, `cur_eflags`, `cur_cs` (zero-extended), return offset.
- R4: With `user_mode` = 0, the stack pointer starts from `cur_esp` and `new_ss` is `cur_ss`. Three words are pushed: `cur_eflags`, `cur_cs` (zero-extended), return offset.
- R5: Each push first lowers the stack pointer by 4 and then writes at the lowered value (`wr_addr`, flat addressing). `new_esp` is the pointer after the last push.
- R6: Exactly one descriptor read is issued, with a one-cycle `rd_req` at `rd_addr` = `idtr[47:16]` + vector*8. The handler is taken from the returned descriptor: `new_cs` = bits 31:16 and `new_eip` = {bits 63:48, bits 15:0}.
- R7: If vector*8+7 exceeds `idtr[15:0]`, the block pulses `err` for one cycle. It issues no read, no write and no `done`. A vector whose last descriptor byte equals the limit is accepted.
- R8: While flag bit 8 (step) of `cur_eflags` is 1, a cycle with `insn_retire` = 1 raises a trap on vector 1.
- R9: `new_eflags` equals the pushed flags word with bit 8 cleared. The pushed word keeps bit 8 as it was.
- R10: `done` is a one-cycle pulse in the cycle after the last push. Requests that arrive while `busy` is high are ignored and cause no later read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 1 | Fault request |
| fault_vec | input | 8 | Fault vector |
| trap_req | input | 1 | Explicit trap request |
| trap_vec | input | 8 | Trap vector |
| intr_req | input | 1 | External interrupt request |
| intr_vec | input | 8 | Interrupt vector |
| insn_retire | input | 1 | An instruction completed this cycle |
| cur_eip | input | 32 | Address of the current instruction |
| next_eip | input | 32 | Address of the following instruction |
| cur_cs | input | 16 | Current code selector |
| cur_eflags | input | 32 | Current flags |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| user_mode | input | 1 | 1 when the core runs in user mode |
| idtr | input | 48 | Descriptor table base (47:16) and limit (15:0) |
| tss_ss | input | 16 | Kernel stack selector |
| tss_esp | input | 32 | Kernel stack pointer |
| rd_req | output | 1 | Descriptor read strobe |
| rd_addr | output | 32 | Descriptor address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Gate descriptor |
| wr_en | output | 1 | Frame write strobe |
| wr_addr | output | 32 | Frame write address |
| wr_data | output | 32 | Frame word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Handler entry ready |
| err | output | 1 | Vector beyond table limit |
| new_cs | output | 16 | Handler code selector |
| new_eip | output | 32 | Handler entry offset |
| new_ss | output | 16 | Stack selector for the handler |
| new_esp | output | 32 | Stack pointer after the frame |
| new_eflags | output | 32 | Working flags for the handler |

## Verification
The bench aims at the places where the frame differs by mode and kind. A design that mixed up the return offset would re-run a trapping instruction or skip a faulting one. A design that did not switch stacks on a user-mode entry would write the frame over the user stack. A design with the push order reversed would return through a corrupted frame. The bench also covers simultaneous requests, where a wrong priority lets an interrupt overtake a fault, and an interrupt while the enable flag is clear, which must leave the block idle. At the limit boundary it uses the last valid vector and the one after it; an off-by-one there either rejects a legal entry or reads past the table. Further cases are a single-step entry, where the handler must see the step flag cleared while the saved copy keeps it, and a request during a busy sequence, which must not start a second read.

// File: rtl/exc_entry_pkg.sv
// Package: shared types and flag positions for the exception entry sequencer.
// Assumes 32-bit flags with step at bit 8 and interrupt enable at bit 9.
package exc_entry_pkg;

    typedef enum logic [1:0] {
        EK_NONE,
        EK_FAULT,
        EK_TRAP,
        EK_INTR
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_PUSH,
        ST_FIN,
        ST_FAIL
    } seq_st_e;

    // Frame slots in push order; a kernel-mode entry starts at SL_FLAGS.
    typedef enum logic [2:0] {
        SL_OLD_SS,
        SL_OLD_ESP,
        SL_FLAGS,
        SL_CODE_SEL,
        SL_RET_IP
    } slot_e;

    localparam int unsigned FLAG_STEP_POS = 8;
    localparam int unsigned FLAG_IE_POS   = 9;
    localparam int unsigned DEBUG_VEC     = 1;

endpackage

// File: rtl/exc_req_arb.sv
// Module: exc_req_arb
// Picks one event out of the requests present in a cycle, with fixed priority
// fault > explicit trap > single-step trap > enabled interrupt.
// Assumes the caller samples the result only while it is idle.
module exc_req_arb
    import exc_entry_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic             fault_req,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             step_hit,
    input  logic             intr_req,
    input  logic [VEC_W-1:0] intr_vec,
    input  logic             intr_en,
    output ev_kind_e         pick_kind,
    output logic [VEC_W-1:0] pick_vec
);

    localparam logic [VEC_W-1:0] STEP_VEC = VEC_W'(DEBUG_VEC);

    // Fixed-priority choice of kind and vector.
    always_comb begin
        pick_kind = EK_NONE;
        pick_vec  = '0;
        if (fault_req) begin
            pick_kind = EK_FAULT;
            pick_vec  = fault_vec;
        end else if (trap_req) begin
            pick_kind = EK_TRAP;
            pick_vec  = trap_vec;
        end else if (step_hit) begin
            pick_kind = EK_TRAP;
            pick_vec  = STEP_VEC;
        end else if (intr_req && intr_en) begin
            pick_kind = EK_INTR;
            pick_vec  = intr_vec;
        end
    end

endmodule

// File: rtl/exc_gate_lookup.sv
// Module: exc_gate_lookup
// Forms the descriptor address from the table base and vector, flags a vector
// whose descriptor would pass the table limit, and decodes a fetched gate into
// handler selector and offset. Assumes an 8-byte descriptor with the offset
// split into low and high halves around the selector and type fields.
module exc_gate_lookup #(
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LIM_W  = 16,
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned DESC_W = 64
) (
    input  logic [VEC_W-1:0]        vec,
    input  logic [LIM_W+WORD_W-1:0] idtr,
    input  logic [DESC_W-1:0]       desc,
    output logic [WORD_W-1:0]       gate_addr,
    output logic                    over_limit,
    output logic [SEL_W-1:0]        hnd_sel,
    output logic [WORD_W-1:0]       hnd_off
);

    localparam int unsigned DESC_BYTES = DESC_W / 8;
    localparam int unsigned SCALE_SH   = $clog2(DESC_BYTES);
    localparam int unsigned IDX_W      = LIM_W + 1;
    localparam int unsigned HALF       = WORD_W / 2;

    logic [WORD_W-1:0] tbl_base;
    logic [LIM_W-1:0]  tbl_lim;
    logic [IDX_W-1:0]  last_byte;
    logic [DESC_W-HALF-SEL_W-HALF-1:0] gate_type_unused;

    // Split the table register into base and limit.
    always_comb begin
        tbl_base = idtr[LIM_W +: WORD_W];
        tbl_lim  = idtr[LIM_W-1:0];
    end

    // Descriptor address and limit test on the last descriptor byte.
    always_comb begin
        gate_addr  = tbl_base + (WORD_W'(vec) << SCALE_SH);
        last_byte  = (IDX_W'(vec) << SCALE_SH) + IDX_W'(DESC_BYTES - 1);
        over_limit = last_byte > IDX_W'(tbl_lim);
    end

    // Gate decode: offset halves and code selector; type bits are not used.
    always_comb begin
        hnd_off          = {desc[DESC_W-1 -: HALF], desc[HALF-1:0]};
        hnd_sel          = desc[HALF +: SEL_W];
        gate_type_unused = desc[HALF+SEL_W +: DESC_W-HALF-SEL_W-HALF];
    end

endmodule

// File: rtl/exc_frame_word.sv
// Module: exc_frame_word
// Selects the word to push for a given frame slot, zero-extending selectors.
// Assumes the slot sequence is driven by the caller.
module exc_frame_word
    import exc_entry_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SEL_W  = 16
) (
    input  slot_e             slot,
    input  logic [SEL_W-1:0]  old_ss,
    input  logic [WORD_W-1:0] old_esp,
    input  logic [WORD_W-1:0] flags,
    input  logic [SEL_W-1:0]  code_sel,
    input  logic [WORD_W-1:0] ret_ip,
    output logic [WORD_W-1:0] word
);

    // Slot to data mux.
    always_comb begin
        case (slot)
            SL_OLD_SS:   word = WORD_W'(old_ss);
            SL_OLD_ESP:  word = old_esp;
            SL_FLAGS:    word = flags;
            SL_CODE_SEL: word = WORD_W'(code_sel);
            default:     word = ret_ip;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Module: exc_entry_seq (top)
// Sequences entry into an exception or interrupt handler: arbitration, table
// limit check, one descriptor read, frame pushes on the kernel or current
// stack, then a done pulse with the handler's selector, offset and stack.
// Assumes the read port answers with rd_valid some cycles after rd_req and the
// write port accepts one word per cycle. Requests are looked at only when idle.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned LIM_W  = 16,
    parameter int unsigned DESC_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fault_req,
    input  logic [VEC_W-1:0]        fault_vec,
    input  logic                    trap_req,
    input  logic [VEC_W-1:0]        trap_vec,
    input  logic                    intr_req,
    input  logic [VEC_W-1:0]        intr_vec,
    input  logic                    insn_retire,
    input  logic [WORD_W-1:0]       cur_eip,
    input  logic [WORD_W-1:0]       next_eip,
    input  logic [SEL_W-1:0]        cur_cs,
    input  logic [WORD_W-1:0]       cur_eflags,
    input  logic [SEL_W-1:0]        cur_ss,
    input  logic [WORD_W-1:0]       cur_esp,
    input  logic                    user_mode,
    input  logic [LIM_W+WORD_W-1:0] idtr,
    input  logic [SEL_W-1:0]        tss_ss,
    input  logic [WORD_W-1:0]       tss_esp,
    output logic                    rd_req,
    output logic [WORD_W-1:0]       rd_addr,
    input  logic                    rd_valid,
    input  logic [DESC_W-1:0]       rd_data,
    output logic                    wr_en,
    output logic [WORD_W-1:0]       wr_addr,
    output logic [WORD_W-1:0]       wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [SEL_W-1:0]        new_cs,
    output logic [WORD_W-1:0]       new_eip,
    output logic [SEL_W-1:0]        new_ss,
    output logic [WORD_W-1:0]       new_esp,
    output logic [WORD_W-1:0]       new_eflags
);

    localparam logic [WORD_W-1:0] PUSH_STEP = WORD_W'(WORD_W / 8);

    seq_st_e           st;
    slot_e             slot_q;
    ev_kind_e          pick_kind;
    logic [VEC_W-1:0]  pick_vec;
    logic              accept;
    logic              over_limit;
    logic [WORD_W-1:0] gate_addr;
    logic [SEL_W-1:0]  hnd_sel;
    logic [WORD_W-1:0] hnd_off;
    logic [WORD_W-1:0] frame_word;

    logic [WORD_W-1:0] ret_q;
    logic [SEL_W-1:0]  cs_q;
    logic [WORD_W-1:0] efl_q;
    logic [SEL_W-1:0]  old_ss_q;
    logic [WORD_W-1:0] old_esp_q;
    logic [SEL_W-1:0]  stk_ss_q;
    logic [WORD_W-1:0] esp_q;
    logic [WORD_W-1:0] gaddr_q;
    logic [DESC_W-1:0] desc_q;

    exc_req_arb #(
        .VEC_W (VEC_W)
    ) u_arb (
        .fault_req (fault_req),
        .fault_vec (fault_vec),
        .trap_req  (trap_req),
        .trap_vec  (trap_vec),
        .step_hit  (insn_retire && cur_eflags[FLAG_STEP_POS]),
        .intr_req  (intr_req),
        .intr_vec  (intr_vec),
        .intr_en   (cur_eflags[FLAG_IE_POS]),
        .pick_kind (pick_kind),
        .pick_vec  (pick_vec)
    );

    exc_gate_lookup #(
        .VEC_W  (VEC_W),
        .WORD_W (WORD_W),
        .LIM_W  (LIM_W),
        .SEL_W  (SEL_W),
        .DESC_W (DESC_W)
    ) u_gate (
        .vec        (pick_vec),
        .idtr       (idtr),
        .desc       (desc_q),
        .gate_addr  (gate_addr),
        .over_limit (over_limit),
        .hnd_sel    (hnd_sel),
        .hnd_off    (hnd_off)
    );

    exc_frame_word #(
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_frame (
        .slot     (slot_q),
        .old_ss   (old_ss_q),
        .old_esp  (old_esp_q),
        .flags    (efl_q),
        .code_sel (cs_q),
        .ret_ip   (ret_q),
        .word     (frame_word)
    );

    // Accept a picked event only while idle.
    always_comb accept = (st == ST_IDLE) && (pick_kind != EK_NONE);

    // Sequencer state: idle, fetch, wait for descriptor, push, finish or fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (accept) st <= over_limit ? ST_FAIL : ST_FETCH;
                ST_FETCH: st <= ST_WAIT;
                ST_WAIT:  if (rd_valid) st <= ST_PUSH;
                ST_PUSH:  if (slot_q == SL_RET_IP) st <= ST_FIN;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Capture the return state and pick the starting stack on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q     <= '0;
            cs_q      <= '0;
            efl_q     <= '0;
            old_ss_q  <= '0;
            old_esp_q <= '0;
            stk_ss_q  <= '0;
            gaddr_q   <= '0;
        end else if (accept) begin
            ret_q     <= (pick_kind == EK_FAULT) ? cur_eip : next_eip;
            cs_q      <= cur_cs;
            efl_q     <= cur_eflags;
            old_ss_q  <= cur_ss;
            old_esp_q <= cur_esp;
            stk_ss_q  <= user_mode ? tss_ss : cur_ss;
            gaddr_q   <= gate_addr;
        end
    end

    // Frame slot counter: user entries start at the old stack selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SL_FLAGS;
        end else if (accept) begin
            slot_q <= user_mode ? SL_OLD_SS : SL_FLAGS;
        end else if (st == ST_PUSH && slot_q != SL_RET_IP) begin
            slot_q <= slot_e'(slot_q + 3'd1);
        end
    end

    // Working stack pointer: load on acceptance, step down on each push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esp_q <= '0;
        end else if (accept) begin
            esp_q <= user_mode ? tss_esp : cur_esp;
        end else if (st == ST_PUSH) begin
            esp_q <= esp_q - PUSH_STEP;
        end
    end

    // Hold the fetched gate descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (st == ST_WAIT && rd_valid) begin
            desc_q <= rd_data;
        end
    end

    // Port drive from state.
    always_comb begin
        rd_req  = (st == ST_FETCH);
        rd_addr = gaddr_q;
        wr_en   = (st == ST_PUSH);
        wr_addr = esp_q - PUSH_STEP;
        wr_data = frame_word;
        busy    = (st != ST_IDLE);
        done    = (st == ST_FIN);
        err     = (st == ST_FAIL);
    end

    // Handler-side results; step flag cleared in the working flags.
    always_comb begin
        new_cs     = hnd_sel;
        new_eip    = hnd_off;
        new_ss     = stk_ss_q;
        new_esp    = esp_q;
        new_eflags = efl_q;
        new_eflags[FLAG_STEP_POS] = 1'b0;
    end

    // R1: a lone interrupt with enable clear leaves the block idle.
    a_r1_masked_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && intr_req && !fault_req && !trap_req && !insn_retire
         && !cur_eflags[FLAG_IE_POS]) |=> !busy);

    // R5: consecutive pushes go down by one word.
    a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - PUSH_STEP));

    // R6: the descriptor read strobe lasts a single cycle.
    a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R7: a limit error carries no write and no completion.
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_en && !done && !rd_req));

    // R7: the sequence after an error returns to idle without a read.
    a_r7_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!busy && !rd_req));

    // R9: the handler never starts with the step flag set.
    a_r9_step_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !new_eflags[FLAG_STEP_POS]);

    // R10: done is a single pulse followed by idle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/exc_entry_seq_tb.sv
// Bench: behavioural reference model of expected reads, pushes and results,
// compared against the ports on every falling clock edge.
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_req = 0, trap_req = 0, intr_req = 0, insn_retire = 0;
    logic [7:0]  fault_vec = 0, trap_vec = 0, intr_vec = 0;
    logic [31:0] cur_eip = 0, next_eip = 0, cur_eflags = 0, cur_esp = 0, tss_esp = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0, tss_ss = 0;
    logic        user_mode = 0;
    logic [47:0] idtr = 0;
    logic        rd_req, rd_valid = 0;
    logic [31:0] rd_addr;
    logic [63:0] rd_data = 0;
    logic        wr_en, busy, done, err;
    logic [31:0] wr_addr, wr_data, new_eip, new_esp, new_eflags;
    logic [15:0] new_cs, new_ss;

    int nchk = 0, nfail = 0;
    logic [31:0] exp_rd[$];
    logic [31:0] exp_wa[$];
    logic [31:0] exp_wd[$];
    int exp_done = 0, exp_err = 0;
    logic [15:0] e_cs, e_ss;
    logic [31:0] e_eip, e_esp, e_efl;
    string cur_tag = "reset";

    always #5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .fault_req(fault_req), .fault_vec(fault_vec),
        .trap_req(trap_req), .trap_vec(trap_vec),
        .intr_req(intr_req), .intr_vec(intr_vec),
        .insn_retire(insn_retire),
        .cur_eip(cur_eip), .next_eip(next_eip), .cur_cs(cur_cs),
        .cur_eflags(cur_eflags), .cur_ss(cur_ss), .cur_esp(cur_esp),
        .user_mode(user_mode), .idtr(idtr), .tss_ss(tss_ss), .tss_esp(tss_esp),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err),
        .new_cs(new_cs), .new_eip(new_eip), .new_ss(new_ss),
        .new_esp(new_esp), .new_eflags(new_eflags)
    );

    function automatic logic [63:0] gate_of(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, 16'h8E00, {5'd0, a[10:3], 3'b000}, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s [%s]: actual %h expected %h", req, cur_tag, act, expv);
        end
    endtask

    // Memory model: answers a descriptor read three falling edges later.
    int rd_cnt = -1;
    logic [31:0] rd_a;
    always @(negedge clk) begin
        if (rd_cnt == 0) begin
            rd_valid = 1'b1;
            rd_data  = gate_of(rd_a);
        end else begin
            rd_valid = 1'b0;
        end
        if (rd_cnt >= 0) rd_cnt--;
        if (rd_req) begin
            rd_a   = rd_addr;
            rd_cnt = 2;
        end
    end

    // Port monitor: compares every read, push and completion with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req) begin
                if (exp_rd.size() == 0) chk(0, "R6/R10 unexpected read", 64'(rd_addr), 0);
                else begin
                    logic [31:0] a;
                    a = exp_rd.pop_front();
                    chk(rd_addr == a, "R6 read address", 64'(rd_addr), 64'(a));
                end
            end
            if (wr_en) begin
                if (exp_wa.size() == 0) chk(0, "R3/R4 unexpected push", 64'(wr_addr), 0);
                else begin
                    logic [31:0] a, d;
                    a = exp_wa.pop_front();
                    d = exp_wd.pop_front();
                    chk(wr_addr == a, "R5 push address", 64'(wr_addr), 64'(a));
                    chk(wr_data == d, "R2/R3/R4 push data", 64'(wr_data), 64'(d));
                end
            end
            if (done) begin
                chk(exp_done > 0, "R10 unexpected done", 1, 0);
                chk(exp_wa.size() == 0, "R10 done before last push", 64'(exp_wa.size()), 0);
                chk(new_cs == e_cs, "R6 handler selector", 64'(new_cs), 64'(e_cs));
                chk(new_eip == e_eip, "R6 handler offset", 64'(new_eip), 64'(e_eip));
                chk(new_ss == e_ss, "R3/R4 stack selector", 64'(new_ss), 64'(e_ss));
                chk(new_esp == e_esp, "R5 final stack pointer", 64'(new_esp), 64'(e_esp));
                chk(new_eflags == e_efl, "R9 working flags", 64'(new_eflags), 64'(e_efl));
                if (exp_done > 0) exp_done--;
            end
            if (err) begin
                chk(exp_err > 0, "R7 unexpected err", 1, 0);
                if (exp_err > 0) exp_err--;
            end
        end
    end

    task automatic push_exp(inout logic [31:0] sp, input logic [31:0] d);
        sp = sp - 32'd4;
        exp_wa.push_back(sp);
        exp_wd.push_back(d);
    endtask

    // Reference model: derives the whole expected sequence from current inputs.
    task automatic predict(output bit took);
        logic [7:0]  v;
        logic [31:0] ret, ga, sp;
        logic [63:0] g;
        int kind;
        kind = 0;
        if (fault_req) begin kind = 1; v = fault_vec; end
        else if (trap_req) begin kind = 2; v = trap_vec; end
        else if (insn_retire && cur_eflags[8]) begin kind = 2; v = 8'd1; end
        else if (intr_req && cur_eflags[9]) begin kind = 3; v = intr_vec; end
        took = (kind != 0);
        if (!took) return;
        ret = (kind == 1) ? cur_eip : next_eip;
        if (int'(v) * 8 + 7 > int'(idtr[15:0])) begin
            exp_err++;
            return;
        end
        ga = idtr[47:16] + 32'(v) * 32'd8;
        exp_rd.push_back(ga);
        g  = gate_of(ga);
        sp = user_mode ? tss_esp : cur_esp;
        if (user_mode) begin
            push_exp(sp, 32'(cur_ss));
            push_exp(sp, cur_esp);
        end
        push_exp(sp, cur_eflags);
        push_exp(sp, 32'(cur_cs));
        push_exp(sp, ret);
        e_cs  = g[31:16];
        e_eip = {g[63:48], g[15:0]};
        e_ss  = user_mode ? tss_ss : cur_ss;
        e_esp = sp;
        e_efl = cur_eflags & ~32'h100;
        exp_done++;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_rd.size() == 0 && exp_wa.size() == 0 && exp_done == 0 && exp_err == 0,
            "R10 sequence complete", 64'(exp_wa.size() + exp_done + exp_err), 0);
    endtask

    task automatic fire(input bit f, input bit t, input bit s, input bit i, input string tag);
        bit took;
        @(negedge clk);
        cur_tag = tag;
        fault_req = f; trap_req = t; insn_retire = s; intr_req = i;
        predict(took);
        @(negedge clk);
        fault_req = 0; trap_req = 0; insn_retire = 0; intr_req = 0;
        if (!took) chk(!busy, "R1 request not taken", 64'(busy), 0);
        wait_end();
    endtask

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog R10: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !wr_en && !rd_req, "R10 reset state",
            64'({busy, done, err, wr_en, rd_req}), 0);
        rst_n = 1'b1;
        idtr = {32'h0010_0000, 16'h07FF};
        cur_cs = 16'h0023; cur_ss = 16'h002B; tss_ss = 16'h0018;
        cur_esp = 32'h0000_8000; tss_esp = 32'h00C0_0000;
        cur_eip = 32'h0040_1000; next_eip = 32'h0040_1003;
        cur_eflags = 32'h0000_0202;

        // R4, R2: kernel-mode page fault, return to faulting instruction.
        user_mode = 0; fault_vec = 8'd14;
        fire(1, 0, 0, 0, "R4 kernel fault");

        // R3: user-mode interrupt switches stacks and pushes five words.
        user_mode = 1; intr_vec = 8'h40; cur_eip = 32'h0804_8010; next_eip = 32'h0804_8012;
        fire(0, 0, 0, 1, "R3 user interrupt");

        // R1: interrupt with enable clear is dropped.
        cur_eflags = 32'h0000_0002;
        fire(0, 0, 0, 1, "R1 masked interrupt");

        // R1: all three at once, fault wins.
        cur_eflags = 32'h0000_0202; fault_vec = 8'd13; trap_vec = 8'd3; intr_vec = 8'h21;
        fire(1, 1, 0, 1, "R1 fault first");

        // R1, R2: trap beats interrupt and returns past the instruction.
        user_mode = 0;
        fire(0, 1, 0, 1, "R1 trap over interrupt");

        // R8, R9: single step raises vector 1, handler sees step cleared.
        cur_eflags = 32'h0000_0302; user_mode = 1;
        fire(0, 0, 1, 0, "R8 single step");

        // R1: explicit trap outranks the step trap.
        trap_vec = 8'h80;
        fire(0, 1, 1, 0, "R1 trap over step");

        // R7: limit boundary, last valid vector then one past.
        cur_eflags = 32'h0000_0202; user_mode = 0;
        idtr = {32'h0020_0000, 16'h0107};
        fault_vec = 8'd32;
        fire(1, 0, 0, 0, "R7 last valid vector");
        fault_vec = 8'd33;
        fire(1, 0, 0, 0, "R7 past limit");
        intr_vec = 8'hFF;
        fire(0, 0, 0, 1, "R7 high vector");

        // R10: a request during a busy sequence is ignored.
        idtr = {32'h0010_0000, 16'h07FF};
        @(negedge clk);
        cur_tag = "R10 busy ignore";
        begin
            bit took;
            fault_req = 1; fault_vec = 8'd6;
            predict(took);
            @(negedge clk);
            fault_req = 0;
            repeat (2) @(negedge clk);
            chk(busy, "R10 busy during sequence", 64'(busy), 1);
            fault_req = 1; fault_vec = 8'd0;
            @(negedge clk);
            fault_req = 0;
        end
        wait_end();

        // R5: kernel stack near a wrap, pointer steps down across it.
        cur_esp = 32'h0000_0008; user_mode = 0; trap_vec = 8'd4;
        fire(0, 1, 0, 0, "R5 low stack");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule